// File: doc/BRIEF.md
# Down-Counting Reload Timer with Compare Flag

This block is a word-addressed periodic timer. A down-counter runs from one of three input tick enables. The selected enable passes through a programmable divider before it reaches the counter. When the counter passes zero, it either reloads from a load register or continues from the all-ones value. Whenever a tick moves the counter onto the value of a compare register, a sticky status flag is set. That flag drives the interrupt line when both the timer enable and the compare interrupt enable are on.

Software configures the block through one control word. The fields of that word select the tick source and the divide ratio. They also choose between reload and free-run behaviour, decide whether enabling the timer restarts the count, and decide whether a write to the load register is copied into the counter at once. A software-reset bit in the same word returns the block to a known state. Only the enable bits survive a software reset. The four low-power enable bits are stored but have no effect.

A small state machine tracks whether the timer is counting. Its states are OFF (enable clear), GATED (enable set but clock-source code 0) and RUN (enable set and a source selected). Its transitions are T_ENABLE (OFF to GATED or RUN), T_DISABLE (GATED or RUN to OFF), T_CLK_ON (GATED to RUN) and T_CLK_OFF (RUN to GATED). On T_ENABLE, when the enable-mode bit is set, the state machine requests a restart of the counter. The state machine updates one cycle after the control write that causes the transition.

Top module: `rct_top`

## Requirements
- R1: Word offsets: 0 control, 1 status, 2 load, 3 compare, 4 count (read-only). A read returns its data on `bus_rdata` in the cycle after the read cycle. A read of any other offset returns 0. A write to any other offset changes no register.
- R2: Control writes keep only bits 25:0, and bits 31:26 always read as 0. Control layout:
  - bit 0: enable
  - bit 1: enable-mode
  - bit 2: compare interrupt enable
  - bit 3: reload mode
  - bits 15:4: prescaler
  - bit 16: software reset
  - bit 17: immediate overwrite
  - bits 18, 19, 21 and 22: low-power enables
  - bits 25:24: clock source
- R3: Clock-source code 0 freezes the counter even when enabled. Codes 1, 2 and 3 select `tick_src[0]`, `tick_src[1]` and `tick_src[2]`, and the sources that are not selected have no effect.
- R4: With prescaler value P, the counter steps once for every P+1 cycles in which the selected source is high.
- R5: The status register has only bit 0, the compare flag. Writing 1 to bit 0 clears the flag. Writing 0 leaves it unchanged.
- R6: `irq` is high only while the compare flag, the compare interrupt enable and the enable bit are all set.
- R7: The compare flag is set by a tick that moves the counter onto the compare value, whether or not the compare interrupt enable is set.
- R8: A tick at count 0 loads the load register in reload mode, and 0xFFFFFFFF otherwise. At any other count, a tick decrements the counter by 1.
- R9: With enable-mode set, a 0-to-1 change of the enable bit loads the counter with the load register (reload mode) or 0xFFFFFFFF. With enable-mode clear, the count is kept.
- R10: With immediate overwrite set, a load write also writes the counter. With it clear, the counter is unchanged.
- R11: A control write with bit 16 set is a software reset:
  - control keeps only bits 0, 1, 18, 19, 21 and 22, and bit 16 reads back 0;
  - status and compare become 0;
  - load and count become 0xFFFFFFFF;
  - the clock source is cleared, so counting stops.
- R12: Hard reset gives control 0, status 0, compare 0, load 0xFFFFFFFF and count 0xFFFFFFFF.
- R13: If a compare match and a write-1 clear of the flag fall in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| tick_src | input | 3 | Three candidate tick enables |
| irq | output | 1 | Compare interrupt |

## Verification
A compare match and a software clear of the status flag can fall in the same clock edge. The bench provokes this by raising the selected tick source in the same cycle as a write of 1 to status, with the counter one step above the compare value. It then judges the result by reading status back: it must read 1 and `irq` must stay high. Reading 0 would mean the clear took priority over the set.

// File: rtl/rct_pkg.sv
package rct_pkg;
    // control word field positions (the layout software relies on)
    localparam int B_EN     = 0;
    localparam int B_ENMOD  = 1;
    localparam int B_CIE    = 2;
    localparam int B_RLD    = 3;
    localparam int B_PRE_LO = 4;
    localparam int B_SWR    = 16;
    localparam int B_OVW    = 17;
    localparam int B_DBG    = 18;
    localparam int B_WAIT   = 19;
    localparam int B_DOZE   = 21;
    localparam int B_STOP   = 22;
    localparam int B_CLK_LO = 24;
    localparam int CTRL_BITS = 26;

    // register word offsets
    localparam int OFS_CTRL = 0;
    localparam int OFS_STAT = 1;
    localparam int OFS_LOAD = 2;
    localparam int OFS_CMP  = 3;
    localparam int OFS_CNT  = 4;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_GATED = 2'd1,
        ST_RUN   = 2'd2
    } run_state_e;
endpackage

// File: rtl/rct_tick_gen.sv
module rct_tick_gen #(
    parameter int NSRC  = 3,
    parameter int SEL_W = 2,
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src,
    input  logic [SEL_W-1:0] sel,
    input  logic [PRE_W-1:0] presc,
    input  logic             run,
    output logic             tick
);
    localparam int NCODE = 1 << SEL_W;

    logic [NCODE-1:0] code_src;
    logic [PRE_W-1:0] div_q;
    logic             pulse;

    // code 0 is "no clock"; codes 1..NSRC map onto the source vector
    generate
        for (genvar k = 0; k < NCODE; k++) begin : g_code
            if (k == 0 || k > NSRC) begin : g_none
                assign code_src[k] = 1'b0;
            end else begin : g_src
                assign code_src[k] = src[k-1];
            end
        end
    endgenerate

    assign pulse = code_src[sel];
    assign tick  = run && pulse && (div_q >= presc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run) begin
            div_q <= '0;
        end else if (pulse) begin
            div_q <= tick ? '0 : div_q + 1'b1;
        end
    end
endmodule

// File: rtl/rct_run_fsm.sv
module rct_run_fsm
    import rct_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clk_on,
    input  logic enmod,
    output logic run,
    output logic start_load
);
    run_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en) state_d = clk_on ? ST_RUN : ST_GATED;   // T_ENABLE
            end
            ST_GATED: begin
                if (!en)        state_d = ST_OFF;               // T_DISABLE
                else if (clk_on) state_d = ST_RUN;              // T_CLK_ON
            end
            ST_RUN: begin
                if (!en)         state_d = ST_OFF;              // T_DISABLE
                else if (!clk_on) state_d = ST_GATED;           // T_CLK_OFF
            end
            default: state_d = ST_OFF;
        endcase
    end

    // outputs
    always_comb begin
        run        = 1'b0;
        start_load = 1'b0;
        unique case (state_q)
            ST_OFF:   start_load = en && enmod;
            ST_GATED: run = 1'b0;
            ST_RUN:   run = 1'b1;
            default:  run = 1'b0;
        endcase
    end
endmodule

// File: rtl/rct_counter.sv
module rct_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              ovw_we,
    input  logic [DATA_W-1:0] ovw_val,
    input  logic              start_load,
    input  logic              reload_mode,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] cmp_val,
    input  logic              tick,
    output logic [DATA_W-1:0] cnt_q,
    output logic              match_set
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    logic [DATA_W-1:0] cnt_d;
    logic [DATA_W-1:0] start_val;

    assign start_val = reload_mode ? load_val : ALL_ONES;

    always_comb begin
        cnt_d     = cnt_q;
        match_set = 1'b0;
        if (soft_clr) begin
            cnt_d = ALL_ONES;
        end else if (ovw_we) begin
            cnt_d = ovw_val;
        end else if (start_load) begin
            cnt_d = start_val;
        end else if (tick) begin
            cnt_d     = (cnt_q == '0) ? start_val : cnt_q - 1'b1;
            match_set = (cnt_d == cmp_val);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= ALL_ONES;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rct_top.sv
module rct_top
    import rct_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AW     = 4,
    parameter int NSRC   = 3,
    parameter int SEL_W  = 2,
    parameter int PRE_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   tick_src,
    output logic              irq
);
    localparam logic [DATA_W-1:0] ALL_ONES   = '1;
    localparam logic [DATA_W-1:0] CTRL_WMASK = DATA_W'((64'd1 << CTRL_BITS) - 64'd1);
    localparam logic [DATA_W-1:0] SOFT_KEEP  = DATA_W'((64'd1 << B_EN)   | (64'd1 << B_ENMOD) |
                                                       (64'd1 << B_DBG)  | (64'd1 << B_WAIT)  |
                                                       (64'd1 << B_DOZE) | (64'd1 << B_STOP));

    logic [DATA_W-1:0] ctrl_q, load_q, cmp_q, rdata_q, cnt_q;
    logic              status_q;
    logic              bus_we, bus_re;
    logic              we_ctrl, we_stat, we_load, we_cmp;
    logic [DATA_W-1:0] ctrl_wv;
    logic              soft_clr, ovw_we, w1c;
    logic              clk_on, fsm_run, start_load, tick, match_set;
    logic [SEL_W-1:0]  clk_sel;
    logic [PRE_W-1:0]  presc;

    // bus decode
    assign bus_we   = bus_sel && bus_wr;
    assign bus_re   = bus_sel && !bus_wr;
    assign we_ctrl  = bus_we && (bus_addr == AW'(OFS_CTRL));
    assign we_stat  = bus_we && (bus_addr == AW'(OFS_STAT));
    assign we_load  = bus_we && (bus_addr == AW'(OFS_LOAD));
    assign we_cmp   = bus_we && (bus_addr == AW'(OFS_CMP));
    assign ctrl_wv  = bus_wdata & CTRL_WMASK;
    assign soft_clr = we_ctrl && ctrl_wv[B_SWR];
    assign ovw_we   = we_load && ctrl_q[B_OVW];
    assign w1c      = we_stat && bus_wdata[0];

    assign clk_sel  = ctrl_q[B_CLK_LO +: SEL_W];
    assign presc    = ctrl_q[B_PRE_LO +: PRE_W];
    assign clk_on   = (clk_sel != '0);

    // control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ctrl_q <= '0;
        else if (soft_clr) ctrl_q <= ctrl_wv & SOFT_KEEP;
        else if (we_ctrl)  ctrl_q <= ctrl_wv;
    end

    // load and compare registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= ALL_ONES;
            cmp_q  <= '0;
        end else if (soft_clr) begin
            load_q <= ALL_ONES;
            cmp_q  <= '0;
        end else begin
            if (we_load) load_q <= bus_wdata;
            if (we_cmp)  cmp_q  <= bus_wdata;
        end
    end

    // compare flag: a match beats a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         status_q <= 1'b0;
        else if (soft_clr)  status_q <= 1'b0;
        else if (match_set) status_q <= 1'b1;
        else if (w1c)       status_q <= 1'b0;
    end

    // registered read port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_re) begin
            unique case (bus_addr)
                AW'(OFS_CTRL): rdata_q <= ctrl_q;
                AW'(OFS_STAT): rdata_q <= DATA_W'(status_q);
                AW'(OFS_LOAD): rdata_q <= load_q;
                AW'(OFS_CMP):  rdata_q <= cmp_q;
                AW'(OFS_CNT):  rdata_q <= cnt_q;
                default:       rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata = rdata_q;
    assign irq       = status_q && ctrl_q[B_CIE] && ctrl_q[B_EN];

    rct_run_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (ctrl_q[B_EN]),
        .clk_on     (clk_on),
        .enmod      (ctrl_q[B_ENMOD]),
        .run        (fsm_run),
        .start_load (start_load)
    );

    rct_tick_gen #(
        .NSRC  (NSRC),
        .SEL_W (SEL_W),
        .PRE_W (PRE_W)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (tick_src),
        .sel   (clk_sel),
        .presc (presc),
        .run   (fsm_run && ctrl_q[B_EN] && clk_on),
        .tick  (tick)
    );

    rct_counter #(
        .DATA_W (DATA_W)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_clr    (soft_clr),
        .ovw_we      (ovw_we),
        .ovw_val     (bus_wdata),
        .start_load  (start_load),
        .reload_mode (ctrl_q[B_RLD]),
        .load_val    (load_q),
        .cmp_val     (cmp_q),
        .tick        (tick),
        .cnt_q       (cnt_q),
        .match_set   (match_set)
    );
endmodule

// File: rtl/rct_checker.sv
module rct_checker #(
    parameter int DATA_W = 32,
    parameter int AW     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [AW-1:0]     bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic [DATA_W-1:0] ctrl_q,
    input logic              status_q,
    input logic [DATA_W-1:0] cmp_q,
    input logic [DATA_W-1:0] cnt_q,
    input logic              tick,
    input logic              start_load,
    input logic              match_set,
    input logic              soft_clr
);
    logic bus_we, rd_unmapped, rd_ctrl, w1c_stat;
    assign bus_we      = bus_sel && bus_wr;
    assign rd_unmapped = bus_sel && !bus_wr && (bus_addr > AW'(4));
    assign rd_ctrl     = bus_sel && !bus_wr && (bus_addr == '0);
    assign w1c_stat    = bus_we && (bus_addr == AW'(1)) && bus_wdata[0];

    p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_unmapped |=> (bus_rdata == '0));

    p_ctrl_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctrl |=> (bus_rdata[DATA_W-1:26] == '0));

    p_frozen_no_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[25:24] == 2'b00 && !bus_we && !start_load) |=> $stable(cnt_q));

    p_w1c_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_stat && !match_set) |=> !status_q);

    p_irq_rise_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($rose(status_q) || $past(bus_we)));

    p_flag_on_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q) |-> (cnt_q == $past(cmp_q)));

    p_step_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q != '0 && !bus_we && !start_load) |=> (cnt_q == $past(cnt_q) - 1'b1));

    p_wrap_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == '0 && !ctrl_q[3] && !bus_we && !start_load) |=> (cnt_q == '1));

    p_set_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (match_set && !soft_clr) |=> status_q);
endmodule

bind rct_top rct_checker #(.DATA_W(DATA_W), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq        (irq),
    .ctrl_q     (ctrl_q),
    .status_q   (status_q),
    .cmp_q      (cmp_q),
    .cnt_q      (cnt_q),
    .tick       (tick),
    .start_load (start_load),
    .match_set  (match_set),
    .soft_clr   (soft_clr)
);

// File: tb/tb_rct_top.sv
module tb_rct_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  tick_src = '0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;   // 250 MHz

    rct_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_src  (tick_src),
        .irq       (irq)
    );

    // control encodings (R2 layout)
    localparam logic [31:0] C_EN = 32'h1, C_ENMOD = 32'h2, C_CIE = 32'h4, C_RLD = 32'h8;
    localparam logic [31:0] C_SWR = 32'h1_0000, C_OVW = 32'h2_0000;
    localparam logic [31:0] C_LP  = 32'h6C_0000;
    localparam logic [31:0] CK1 = 32'h0100_0000, CK2 = 32'h0200_0000, CK3 = 32'h0300_0000;

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        @(negedge clk);
    endtask

    // driver: issue a read and push the expected value for the monitor
    task automatic rd_exp(input logic [3:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic run_src(input int idx, input int n);
        @(negedge clk);
        tick_src[idx] = 1'b1;
        repeat (n) @(negedge clk);
        tick_src = '0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        total++;
        if (irq !== e) begin
            bad++;
            $display("FAIL %s: irq actual=%0b expected=%0b", tag, irq, e);
        end
    endtask

    // monitor: pop and compare as read data appears
    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && bus_sel && !bus_wr) begin
                @(negedge clk);
                if (exp_q.size() > 0) begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    total++;
                    if (bus_rdata !== e) begin
                        bad++;
                        $display("FAIL %s: rdata actual=%h expected=%h", t, bus_rdata, e);
                    end
                end
            end
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        rd_exp(0, 32'h0, "R12 ctrl");
        rd_exp(1, 32'h0, "R12 status");
        rd_exp(2, 32'hFFFF_FFFF, "R12 load");
        rd_exp(3, 32'h0, "R12 cmp");
        rd_exp(4, 32'hFFFF_FFFF, "R12 count");
        chk_irq(1'b0, "R12 irq");

        // R1 unmapped
        rd_exp(5, 32'h0, "R1 unmapped read");
        wr(7, 32'h1234_5678);
        rd_exp(2, 32'hFFFF_FFFF, "R1 unmapped write ignored");

        // R2 upper bits
        wr(0, 32'hFC00_0000 | C_OVW);
        rd_exp(0, C_OVW, "R2 upper bits dropped");
        wr(0, 32'h0);

        // R9 + R3
        wr(2, 32'd100);
        wr(0, C_EN | C_ENMOD | C_RLD);
        rd_exp(4, 32'd100, "R9 enable loads start");
        run_src(0, 10);
        rd_exp(4, 32'd100, "R3 frozen at code 0");
        wr(0, C_EN | C_ENMOD | C_RLD | CK1);
        run_src(1, 5);
        rd_exp(4, 32'd100, "R3 unselected source");
        run_src(0, 7);
        rd_exp(4, 32'd93, "R3 source 1 counts");
        wr(0, C_EN | C_ENMOD | C_RLD | CK3);
        run_src(0, 4);
        run_src(2, 3);
        rd_exp(4, 32'd90, "R3 source 3 counts");

        // R4 prescaler 3
        wr(0, 32'h0);
        wr(0, C_EN | C_ENMOD | C_RLD | CK1 | 32'h30);
        run_src(0, 10);
        rd_exp(4, 32'd98, "R4 divide by 4");
        run_src(0, 2);
        rd_exp(4, 32'd97, "R4 remainder carried");

        // R8 reload
        wr(0, 32'h0);
        wr(2, 32'd3);
        wr(0, C_EN | C_ENMOD | C_RLD | CK1);
        run_src(0, 3);
        rd_exp(4, 32'd0, "R8 reach zero");
        run_src(0, 1);
        rd_exp(4, 32'd3, "R8 reload");
        run_src(0, 2);
        rd_exp(4, 32'd1, "R8 after reload");

        // R9 free-run start, R10 overwrite, R8 wrap
        wr(0, 32'h0);
        wr(0, C_EN | C_ENMOD | CK1);
        rd_exp(4, 32'hFFFF_FFFF, "R9 free-run start");
        run_src(0, 1);
        rd_exp(4, 32'hFFFF_FFFE, "R8 step");
        wr(0, C_EN | C_OVW | CK1);
        wr(2, 32'd2);
        rd_exp(4, 32'd2, "R10 overwrite");
        run_src(0, 3);
        rd_exp(4, 32'hFFFF_FFFF, "R8 free-run wrap");
        wr(0, C_EN | CK1);
        wr(2, 32'd50);
        rd_exp(4, 32'hFFFF_FFFF, "R10 no overwrite");
        rd_exp(2, 32'd50, "R1 load readback");
        wr(1, 32'h1);
        rd_exp(1, 32'h0, "R5 w1c");

        // R7 / R6 / R5
        wr(0, 32'h0);
        wr(3, 32'd5);
        wr(2, 32'd8);
        wr(0, C_EN | C_ENMOD | C_RLD | CK1);
        run_src(0, 2);
        rd_exp(1, 32'h0, "R7 no match yet");
        run_src(0, 1);
        rd_exp(1, 32'h1, "R7 flag without cie");
        chk_irq(1'b0, "R6 cie off");
        wr(0, C_EN | C_CIE | C_RLD | CK1);
        chk_irq(1'b1, "R6 all set");
        wr(1, 32'h0);
        rd_exp(1, 32'h1, "R5 write 0 no effect");
        wr(0, C_CIE | C_RLD | CK1);
        chk_irq(1'b0, "R6 enable off");
        wr(0, C_EN | C_CIE | C_RLD | CK1);
        rd_exp(4, 32'd5, "R9 no load without enmod");
        chk_irq(1'b1, "R6 enable back");
        wr(1, 32'h1);
        rd_exp(1, 32'h0, "R5 clear");
        chk_irq(1'b0, "R6 flag cleared");

        // R13 set and clear in the same cycle
        wr(3, 32'd4);
        @(negedge clk);
        tick_src[0] = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd1; bus_wdata = 32'h1;
        @(negedge clk);
        tick_src = '0; bus_sel = 1'b0; bus_wr = 1'b0;
        rd_exp(1, 32'h1, "R13 set wins");
        rd_exp(4, 32'd4, "R13 count");
        chk_irq(1'b1, "R13 irq");

        // R11 soft reset
        wr(0, C_EN | C_ENMOD | C_CIE | C_RLD | 32'h20 | C_OVW | C_LP | CK2);
        wr(2, 32'd77);
        rd_exp(4, 32'd77, "R10 overwrite while running");
        wr(0, C_EN | C_ENMOD | C_CIE | C_RLD | 32'h20 | C_OVW | C_LP | CK2 | C_SWR);
        rd_exp(0, C_EN | C_ENMOD | C_LP, "R11 ctrl kept bits");
        rd_exp(1, 32'h0, "R11 status");
        rd_exp(3, 32'h0, "R11 cmp");
        rd_exp(2, 32'hFFFF_FFFF, "R11 load");
        rd_exp(4, 32'hFFFF_FFFF, "R11 count");
        run_src(1, 5);
        rd_exp(4, 32'hFFFF_FFFF, "R11 counting stopped");
        chk_irq(1'b0, "R11 irq");

        // R12 hard reset after activity
        wr(3, 32'd9);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_exp(0, 32'h0, "R12 ctrl after reset");
        rd_exp(3, 32'h0, "R12 cmp after reset");
        rd_exp(2, 32'hFFFF_FFFF, "R12 load after reset");
        rd_exp(4, 32'hFFFF_FFFF, "R12 count after reset");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL scoreboard: pending actual=%0d expected=0", exp_q.size());
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule